// File: doc/BRIEF.md
# PCIe Bridge Interrupt Aggregator

This block gathers every interrupt-worthy condition of a bus-to-PCIe bridge and reduces it to one interrupt line. The sources are link events, single-bit and double-bit ECC flags from four internal buffers, DMA and address-translation events, the four legacy INTx wires, a host-side event group, and inbound MSI writes. Each source pulse sets a sticky status bit. A mask or enable bit gates that status bit before it reaches the shared output.

Software works through a 32-bit register port. Writes are single-cycle. Reads are combinational from the word index. Status bits are cleared by writing 1. The mask polarity is not the same for every group: the local and host groups use 1 = enable, while the link and ECC groups use 1 = masked. An inbound write to the MSI target address sets one of 32 vector bits and also sets a summary bit in the local status. Two saturating counters track how many cycles carried ECC errors.

Top module: `pcie_irq_aggr`

## Requirements
- R1: Local status (word 0) latches `localEvt` pulses only at implemented bits 0–1, 8–9 and 16–31. Bits 2–7 and 10–15 always read 0. Writing 1 to a bit of word 0 clears it, and writing 0 leaves it unchanged.
- R2: Local enable (word 1, reset 0, fully read/write) lets a local status bit reach `irqOut` only where its enable bit is 1.
- R3: A cycle with `msiValid`, `msiAddr` equal to `MSI_TARGET` and `msiData` below 32 sets bit `msiData` of MSI status (word 2) and bit 28 of local status.
- R4: MSI status bits clear on a write of 1. An MSI write to another address, or with data of 32 or more, changes nothing.
- R5: Link word (word 3) holds three status bits at [2:0], set by `linkEvt` and cleared by writing 1. It also holds three mask bits at [18:16], written directly, reset to 1. A mask bit of 1 blocks its event from `irqOut`.
- R6: Single-bit status (word 4) and double-bit status (word 6) are 16 bits each, set by `secEvt` and `dedEvt` and cleared by writing 1. Their masks (words 5 and 7) reset to all ones, and a 1 blocks the bit.
- R7: The single-bit counter (word 8) and the double-bit counter (word 9) each add 1 in every cycle in which any bit of their event vector is high. Writing 0 clears the counter, and that clear wins over an increment in the same cycle. A nonzero write is ignored.
- R8: The counters stop at 2^CNT_W−1 and never wrap.
- R9: Host status (word 10) is set by `hostEvt`, is cleared by writing 1, and a write of all ones clears all of it. Host enable (word 11) resets to 0 (everything masked), and 1 enables a bit.
- R10: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R11: `irqOut` is a register. It is the OR of all enabled pending bits of every group, taken from the status and mask values present one clock edge earlier.
- R12: After reset, all status registers, both counters and `irqOut` are 0. Unmapped words 12–15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| localEvt | input | 32 | Local event pulses, one per local status bit |
| linkEvt | input | 3 | Link event pulses |
| secEvt | input | 16 | Single-bit ECC error pulses, four per buffer |
| dedEvt | input | 16 | Double-bit ECC error pulses, four per buffer |
| hostEvt | input | 32 | Host event pulses |
| msiValid | input | 1 | Inbound write valid |
| msiAddr | input | 32 | Inbound write address |
| msiData | input | 32 | Inbound write data (vector number) |
| irqOut | output | 1 | Combined interrupt |

## Verification
Directed cases drive every local event at once, which separates the implemented bits from the reserved ones. They also drive an event together with a clearing write on the same bit, which separates set priority from clear priority. Valid, wrong-address and out-of-range MSI writes distinguish capture from rejection. Opposite-polarity mask writes show that the link and ECC groups block on 1 while the local and host groups pass on 1, and a long error burst drives a counter into saturation. A seeded random phase then mixes sparse events with writes to random words and random data. A bench model checks every register and the one-cycle-late interrupt against it.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 4;
  localparam int ECC_W = 16;
  localparam int LINK_W = 3;
  localparam int MSI_N = 32;
  localparam int VEC_W = $clog2(MSI_N);
  localparam int MSI_SUM_BIT = 28;
  localparam int LINK_MASK_LSB = 16;
  localparam logic [REG_W-1:0] LOCAL_IMPL = 32'hFFFF_0303;

  typedef enum logic [ADDR_W-1:0] {
    W_LOC_STAT  = 4'd0,
    W_LOC_EN    = 4'd1,
    W_MSI_STAT  = 4'd2,
    W_LINK      = 4'd3,
    W_SEC_STAT  = 4'd4,
    W_SEC_MASK  = 4'd5,
    W_DED_STAT  = 4'd6,
    W_DED_MASK  = 4'd7,
    W_SEC_CNT   = 4'd8,
    W_DED_CNT   = 4'd9,
    W_HOST_STAT = 4'd10,
    W_HOST_EN   = 4'd11
  } regWord_e;

  typedef struct packed {
    logic locClr;
    logic locEn;
    logic msiClr;
    logic linkWr;
    logic secClr;
    logic secMask;
    logic dedClr;
    logic dedMask;
    logic secCntClr;
    logic dedCntClr;
    logic hostClr;
    logic hostEn;
    logic msiHit;
    logic [VEC_W-1:0] msiVec;
  } strobe_t;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] setVec,
  input  logic [W-1:0] clrVec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)          q[i] <= 1'b0;
      else if (setVec[i]) q[i] <= 1'b1;
      else if (clrVec[i]) q[i] <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> q[i]);
    p_w1c_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
      (clrVec[i] && !setVec[i]) |=> !q[i]);
  end
endmodule

// File: rtl/irq_sat_cnt.sv
module irq_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rstN)                  q <= '0;
    else if (clr)               q <= '0;
    else if (inc && q != MAXV)  q <= q + 1'b1;
  end

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (q == MAXV && !clr) |=> q == MAXV);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> q == '0);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import pcie_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] MSI_TARGET = 32'hFEE0_0000
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              msiValid,
  input  logic [REG_W-1:0]  msiAddr,
  input  logic [REG_W-1:0]  msiData,
  output strobe_t           stb
);
  logic wrZero;
  assign wrZero = (regWdata == '0);

  always_comb begin
    stb = '0;
    if (regWe) begin
      case (regAddr)
        W_LOC_STAT:  stb.locClr    = 1'b1;
        W_LOC_EN:    stb.locEn     = 1'b1;
        W_MSI_STAT:  stb.msiClr    = 1'b1;
        W_LINK:      stb.linkWr    = 1'b1;
        W_SEC_STAT:  stb.secClr    = 1'b1;
        W_SEC_MASK:  stb.secMask   = 1'b1;
        W_DED_STAT:  stb.dedClr    = 1'b1;
        W_DED_MASK:  stb.dedMask   = 1'b1;
        W_SEC_CNT:   stb.secCntClr = wrZero;
        W_DED_CNT:   stb.dedCntClr = wrZero;
        W_HOST_STAT: stb.hostClr   = 1'b1;
        W_HOST_EN:   stb.hostEn    = 1'b1;
        default: ;
      endcase
    end
    stb.msiHit = msiValid && (msiAddr == MSI_TARGET) && (msiData < MSI_N);
    stb.msiVec = msiData[VEC_W-1:0];
  end
endmodule

// File: rtl/irq_dp.sv
module irq_dp
  import pcie_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic [REG_W-1:0]  localEvt,
  input  logic [LINK_W-1:0] linkEvt,
  input  logic [ECC_W-1:0]  secEvt,
  input  logic [ECC_W-1:0]  dedEvt,
  input  logic [REG_W-1:0]  hostEvt,
  output logic [REG_W-1:0]  regRdata,
  output logic              irqOut
);
  logic [REG_W-1:0]  locStat, msiStat, hostStat;
  logic [REG_W-1:0]  locSet, msiSet;
  logic [REG_W-1:0]  locEnR, hostEnR;
  logic [LINK_W-1:0] linkStat, linkDis;
  logic [ECC_W-1:0]  secStat, dedStat, secMaskR, dedMaskR;
  logic [CNT_W-1:0]  secCnt, dedCnt;
  logic              anyPend;

  always_comb begin
    locSet = localEvt & LOCAL_IMPL;
    locSet[MSI_SUM_BIT] = locSet[MSI_SUM_BIT] | stb.msiHit;
    msiSet = '0;
    msiSet[stb.msiVec] = stb.msiHit;
  end

  irq_w1c_bank #(.W(REG_W)) u_loc (.clk(clk), .rstN(rstN), .setVec(locSet),
    .clrVec(stb.locClr ? (regWdata & LOCAL_IMPL) : '0), .q(locStat));
  irq_w1c_bank #(.W(REG_W)) u_msi (.clk(clk), .rstN(rstN), .setVec(msiSet),
    .clrVec(stb.msiClr ? regWdata : '0), .q(msiStat));
  irq_w1c_bank #(.W(LINK_W)) u_link (.clk(clk), .rstN(rstN), .setVec(linkEvt),
    .clrVec(stb.linkWr ? regWdata[LINK_W-1:0] : '0), .q(linkStat));
  irq_w1c_bank #(.W(ECC_W)) u_sec (.clk(clk), .rstN(rstN), .setVec(secEvt),
    .clrVec(stb.secClr ? regWdata[ECC_W-1:0] : '0), .q(secStat));
  irq_w1c_bank #(.W(ECC_W)) u_ded (.clk(clk), .rstN(rstN), .setVec(dedEvt),
    .clrVec(stb.dedClr ? regWdata[ECC_W-1:0] : '0), .q(dedStat));
  irq_w1c_bank #(.W(REG_W)) u_host (.clk(clk), .rstN(rstN), .setVec(hostEvt),
    .clrVec(stb.hostClr ? regWdata : '0), .q(hostStat));

  irq_sat_cnt #(.W(CNT_W)) u_secCnt (.clk(clk), .rstN(rstN), .inc(|secEvt),
    .clr(stb.secCntClr), .q(secCnt));
  irq_sat_cnt #(.W(CNT_W)) u_dedCnt (.clk(clk), .rstN(rstN), .inc(|dedEvt),
    .clr(stb.dedCntClr), .q(dedCnt));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locEnR   <= '0;
      hostEnR  <= '0;
      linkDis  <= '1;
      secMaskR <= '1;
      dedMaskR <= '1;
    end else begin
      if (stb.locEn)   locEnR   <= regWdata;
      if (stb.hostEn)  hostEnR  <= regWdata;
      if (stb.linkWr)  linkDis  <= regWdata[LINK_MASK_LSB +: LINK_W];
      if (stb.secMask) secMaskR <= regWdata[ECC_W-1:0];
      if (stb.dedMask) dedMaskR <= regWdata[ECC_W-1:0];
    end
  end

  assign anyPend = |(locStat & locEnR) | |(linkStat & ~linkDis)
                 | |(secStat & ~secMaskR) | |(dedStat & ~dedMaskR)
                 | |(hostStat & hostEnR);

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= anyPend;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      W_LOC_STAT:  regRdata = locStat;
      W_LOC_EN:    regRdata = locEnR;
      W_MSI_STAT:  regRdata = msiStat;
      W_LINK: begin
        regRdata[LINK_W-1:0] = linkStat;
        regRdata[LINK_MASK_LSB +: LINK_W] = linkDis;
      end
      W_SEC_STAT:  regRdata[ECC_W-1:0] = secStat;
      W_SEC_MASK:  regRdata[ECC_W-1:0] = secMaskR;
      W_DED_STAT:  regRdata[ECC_W-1:0] = dedStat;
      W_DED_MASK:  regRdata[ECC_W-1:0] = dedMaskR;
      W_SEC_CNT:   regRdata[CNT_W-1:0] = secCnt;
      W_DED_CNT:   regRdata[CNT_W-1:0] = dedCnt;
      W_HOST_STAT: regRdata = hostStat;
      W_HOST_EN:   regRdata = hostEnR;
      default: ;
    endcase
  end

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (locStat & ~LOCAL_IMPL) == '0);
  p_local_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|(locStat & locEnR)) |=> irqOut);
  p_msi_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.msiHit |=> (locStat[MSI_SUM_BIT] && msiStat[$past(stb.msiVec)]));
  p_link_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|(linkStat & ~linkDis)) |=> irqOut);
  p_host_open_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|(hostStat & hostEnR)) |=> irqOut);
endmodule

// File: rtl/pcie_irq_aggr.sv
module pcie_irq_aggr
  import pcie_irq_pkg::*;
#(
  parameter logic [31:0] MSI_TARGET = 32'hFEE0_0000,
  parameter int          CNT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic [31:0] localEvt,
  input  logic [2:0]  linkEvt,
  input  logic [15:0] secEvt,
  input  logic [15:0] dedEvt,
  input  logic [31:0] hostEvt,
  input  logic        msiValid,
  input  logic [31:0] msiAddr,
  input  logic [31:0] msiData,
  output logic        irqOut
);
  strobe_t stb;

  irq_ctrl #(.MSI_TARGET(MSI_TARGET)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .msiValid(msiValid), .msiAddr(msiAddr), .msiData(msiData), .stb(stb));

  irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .regWdata(regWdata),
    .localEvt(localEvt), .linkEvt(linkEvt), .secEvt(secEvt), .dedEvt(dedEvt),
    .hostEvt(hostEvt), .regRdata(regRdata), .irqOut(irqOut));
endmodule

// File: tb/pcie_irq_aggr_test.sv
`timescale 1ns/1ps
module pcie_irq_aggr_test;
  localparam logic [31:0] TGT  = 32'hFEE0_0000;
  localparam logic [31:0] IMPL = 32'hFFFF_0303;
  localparam int          CW   = 8;
  localparam logic [7:0]  CMAX = 8'hFF;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0, msiValid = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0, localEvt = '0, hostEvt = '0, msiAddr = '0, msiData = '0;
  logic [2:0]  linkEvt = '0;
  logic [15:0] secEvt = '0, dedEvt = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  always #10 clk = ~clk;

  pcie_irq_aggr #(.MSI_TARGET(TGT), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .localEvt(localEvt), .linkEvt(linkEvt), .secEvt(secEvt),
    .dedEvt(dedEvt), .hostEvt(hostEvt), .msiValid(msiValid), .msiAddr(msiAddr),
    .msiData(msiData), .irqOut(irqOut));

  // reference state
  logic [31:0] mLoc, mLocEn, mMsi, mHost, mHostEn;
  logic [2:0]  mLink, mLinkDis;
  logic [15:0] mSec, mSecM, mDed, mDedM;
  logic [7:0]  mSecC, mDedC;
  logic        mIrq;
  int nChk = 0, nFail = 0;
  bit done = 0;

  task automatic modelReset();
    mLoc = 0; mLocEn = 0; mMsi = 0; mHost = 0; mHostEn = 0;
    mLink = 0; mLinkDis = 3'b111; mSec = 0; mSecM = 16'hFFFF;
    mDed = 0; mDedM = 16'hFFFF; mSecC = 0; mDedC = 0; mIrq = 0;
  endtask

  function automatic logic pend();
    return (|(mLoc & mLocEn)) | (|(mLink & ~mLinkDis)) | (|(mSec & ~mSecM))
         | (|(mDed & ~mDedM)) | (|(mHost & mHostEn));
  endfunction

  function automatic logic wr(int a);
    return regWe && (int'(regAddr) == a);
  endfunction

  task automatic modelEdge();
    logic hit;
    hit = msiValid && msiAddr == TGT && msiData < 32;
    mIrq = pend();
    mLoc = (mLoc & ~(wr(0) ? regWdata : 32'h0)) | (localEvt & IMPL);
    if (hit) begin mLoc[28] = 1'b1; end
    mLoc = mLoc & IMPL;
    if (wr(1)) mLocEn = regWdata;
    mMsi = mMsi & ~(wr(2) ? regWdata : 32'h0);
    if (hit) mMsi[msiData[4:0]] = 1'b1;
    mLink = (mLink & ~(wr(3) ? regWdata[2:0] : 3'h0)) | linkEvt;
    if (wr(3)) mLinkDis = regWdata[18:16];
    mSec = (mSec & ~(wr(4) ? regWdata[15:0] : 16'h0)) | secEvt;
    if (wr(5)) mSecM = regWdata[15:0];
    mDed = (mDed & ~(wr(6) ? regWdata[15:0] : 16'h0)) | dedEvt;
    if (wr(7)) mDedM = regWdata[15:0];
    if (wr(8) && regWdata == 0) mSecC = 0;
    else if (|secEvt && mSecC != CMAX) mSecC = mSecC + 1;
    if (wr(9) && regWdata == 0) mDedC = 0;
    else if (|dedEvt && mDedC != CMAX) mDedC = mDedC + 1;
    mHost = (mHost & ~(wr(10) ? regWdata : 32'h0)) | hostEvt;
    if (wr(11)) mHostEn = regWdata;
  endtask

  function automatic logic [31:0] expRead(int a);
    case (a)
      0: return mLoc;   1: return mLocEn;  2: return mMsi;
      3: return {13'h0, mLinkDis, 13'h0, mLink};
      4: return {16'h0, mSec}; 5: return {16'h0, mSecM};
      6: return {16'h0, mDed}; 7: return {16'h0, mDedM};
      8: return {24'h0, mSecC}; 9: return {24'h0, mDedC};
      10: return mHost; 11: return mHostEn;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(int a);
    case (a)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R5";
      4, 5, 6, 7: return "R6"; 8, 9: return "R7";
      10, 11: return "R9"; default: return "R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    for (int a = 0; a < 16; a++) begin
      regAddr = a[3:0];
      #0.3;
      chk(tagOf(a), regRdata, expRead(a));
    end
    chk("R11 irq", {31'h0, irqOut}, {31'h0, mIrq});
  endtask

  // inputs are set before calling; one clock edge is taken, pulses drop after
  task automatic cycle();
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    regWe = 0; localEvt = 0; linkEvt = 0; secEvt = 0; dedEvt = 0;
    hostEvt = 0; msiValid = 0;
  endtask

  task automatic wrReg(int a, logic [31:0] d);
    regWe = 1; regAddr = a[3:0]; regWdata = d;
    cycle();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll();                                // R12 reset state

    // R1: all local events, reserved bits must stay 0
    localEvt = '1; cycle(); checkAll();
    wrReg(0, 32'h0000_0303); checkAll();       // R1 W1C
    // R10: event and clear on bit 16 in one cycle
    localEvt = 32'h0001_0000; regWe = 1; regAddr = 0; regWdata = 32'h0001_0000;
    cycle(); checkAll();
    chk("R10 set wins", regRdata & 0, 0);
    regAddr = 0; #0.3; chk("R10 bit16", {31'h0, regRdata[16]}, 32'h1);
    // R2/R11: enable bit 16, irq rises one edge later
    wrReg(0, 32'hFFFE_FFFF); wrReg(1, 32'h0001_0000);
    chk("R11 latency", {31'h0, irqOut}, 32'h0);
    cycle(); checkAll();
    chk("R2 enabled", {31'h0, irqOut}, 32'h1);
    wrReg(0, '1); wrReg(1, 0); cycle(); checkAll();

    // R3/R4: MSI capture and rejection
    msiValid = 1; msiAddr = TGT; msiData = 5; cycle(); checkAll();
    msiValid = 1; msiAddr = TGT + 4; msiData = 7; cycle();
    msiValid = 1; msiAddr = TGT; msiData = 40; cycle(); checkAll();
    regAddr = 2; #0.3; chk("R4 reject", regRdata, 32'h20);
    wrReg(2, 32'h20); wrReg(0, '1); checkAll();

    // R5: link mask 1 blocks, 0 passes
    linkEvt = 3'b101; cycle(); cycle(); checkAll();
    chk("R5 masked", {31'h0, irqOut}, 32'h0);
    wrReg(3, 0); cycle(); checkAll();
    chk("R5 open", {31'h0, irqOut}, 32'h1);
    wrReg(3, 32'h0007_0007); cycle(); checkAll();

    // R6: ecc status and masks
    secEvt = 16'h00F0; dedEvt = 16'hF000; cycle();
    wrReg(5, 16'hFF0F); cycle(); checkAll();
    wrReg(5, '1); wrReg(4, '1); wrReg(6, '1); wrReg(8, 0); wrReg(9, 0); checkAll();

    // R7/R8: counting, ignored nonzero write, saturation, clear
    for (int i = 0; i < 300; i++) begin secEvt = 16'h0001; cycle(); end
    checkAll();
    regAddr = 8; #0.3; chk("R8 saturate", regRdata, 32'hFF);
    wrReg(8, 32'h5); checkAll();
    secEvt = 16'h1; regWe = 1; regAddr = 8; regWdata = 0; cycle(); checkAll();
    regAddr = 8; #0.3; chk("R7 clear wins", regRdata, 32'h0);
    wrReg(4, '1);

    // R9: host group, all-ones clear
    hostEvt = 32'hA5A5_5A5A; cycle(); cycle(); checkAll();
    chk("R9 reset masked", {31'h0, irqOut}, 32'h0);
    wrReg(11, 32'h0000_0002); cycle(); checkAll();
    wrReg(10, '1); cycle(); checkAll();
    wrReg(11, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      localEvt = $urandom & $urandom & $urandom;
      hostEvt  = $urandom & $urandom & $urandom;
      linkEvt  = 3'($urandom & $urandom);
      secEvt   = 16'($urandom & $urandom & $urandom);
      dedEvt   = 16'($urandom & $urandom & $urandom);
      if ($urandom_range(0, 3) == 0) begin
        msiValid = 1;
        msiAddr  = ($urandom_range(0, 3) == 0) ? TGT + 8 : TGT;
        msiData  = $urandom_range(0, 40);
      end
      if ($urandom_range(0, 2) == 0) begin
        regWe = 1; regAddr = 4'($urandom_range(0, 13));
        case ($urandom_range(0, 3))
          0: regWdata = 0;
          1: regWdata = '1;
          default: regWdata = $urandom;
        endcase
      end
      cycle();
      if (n % 8 == 0) checkAll();
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule